// File: doc/BRIEF.md
# Timer with Compare Channels

A counter/timer that advances once per prescale tick, running from zero up to a programmable period limit (TOP) and then wrapping back to zero. The wrap raises an overflow event. Three compare channels, A, B and C, each hold a compare value and raise a match event on the tick where the counter equals that value. A channel is active only when its value is nonzero and no greater than TOP. A channel whose value equals TOP fires in the same cycle as the overflow.

Software programs TOP, the counter and the three compare values through one write port, selected by a register code. Each event appears as a one-clock pulse and also sets a sticky flag. Software clears a flag by writing 1 to it. A TOP of zero holds the timer idle. Writing TOP restarts the count without producing an overflow.

Top module: `cmp_timer`

## Requirements
- R1: While TOP is nonzero, the counter stays in 0..TOP. On a tick with the counter at TOP, it returns to 0 and an overflow event is raised, so the overflow period is TOP+1 ticks.
- R2: The counter changes only on cycles with `tick` high and no register write. On all other cycles it holds its value.
- R3: Channel i raises a match event on an accepted tick while the counter equals its compare value. This is OCR+1 ticks after the wrap.
- R4: A channel whose compare value is zero, or greater than TOP, never raises a match event.
- R5: A channel whose compare value equals TOP raises its match event in the same cycle as the overflow event.
- R6: Writing TOP (select code 0) loads the new limit and sets the counter to 0, without an overflow event.
- R7: Writing the counter (select code 1) loads the written value, or 0 if that value is at or above the current TOP. Any write cycle ignores `tick`. Compare values use select codes 2, 3 and 4 for channels A, B and C.
- R8: The `flags` bit positions are: bit 0 for overflow, and bits 1, 2 and 3 for channels A, B and C. A flag is set by its event and stays set until cleared by a write with select code 5 that has a 1 in that bit. If an event and a clear land in the same cycle, the event wins.
- R9: With TOP equal to 0, the counter does not advance and no event is raised.
- R10: Event pulses are one clock wide. They are high in the cycle that follows the clock edge of the accepted tick, which is the same edge that updates `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 TOP, 1 counter, 2..4 compare A..C, 5 flag clear |
| wr_data | input | CW | Write data |
| count | output | CW | Current counter value |
| ovf_pulse | output | 1 | Overflow event pulse |
| cmp_pulse | output | NCMP | Match event pulses, bit i for channel i |
| flags | output | NCMP+1 | Sticky event flags |

## Verification
The compare and overflow paths are tried with four input patterns. TOP=4 with sparse ticks separates true period counting from clock counting. A channel at the midpoint and a channel equal to TOP separate an early match from a coincident match. Zero and above-TOP compare values must stay silent. TOP=1 with a tick every cycle shows that pulses stay one clock wide at the fastest wrap rate. Counter writes below, at and above TOP separate loading from forced clearing. Flag clears that coincide with events show whether set or clear has priority.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CW   = 16,
  parameter int NCMP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [CW-1:0]   wr_data,
  output logic [CW-1:0]   count,
  output logic            ovf_pulse,
  output logic [NCMP-1:0] cmp_pulse,
  output logic [NCMP:0]   flags
);
  localparam logic [2:0] SEL_TOP = 3'd0;
  localparam logic [2:0] SEL_CNT = 3'd1;
  localparam logic [2:0] SEL_CMP = 3'd2;
  localparam logic [2:0] SEL_CLR = 3'd5;

  logic [CW-1:0]   top_q, cnt_q;
  logic [CW-1:0]   ocr_q [NCMP];
  logic [NCMP-1:0] hit;
  logic [NCMP:0]   clr;

  wire adv  = tick && !wr_en && (top_q != '0);
  wire wrap = adv && (cnt_q == top_q);

  assign count = cnt_q;
  assign clr   = (wr_en && wr_sel == SEL_CLR) ? wr_data[NCMP:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (wr_en && wr_sel == SEL_TOP) begin
      top_q <= wr_data;
      cnt_q <= '0;
    end else if (wr_en && wr_sel == SEL_CNT) begin
      cnt_q <= (wr_data >= top_q) ? '0 : wr_data;
    end else if (adv) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_pulse <= 1'b0;
      cmp_pulse <= '0;
      flags     <= '0;
    end else begin
      ovf_pulse <= wrap;
      cmp_pulse <= hit;
      flags     <= {hit, wrap} | (flags & ~clr);
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_ch
    localparam logic [2:0] MY_SEL = SEL_CMP + 3'(i);
    wire live = (ocr_q[i] != '0) && (ocr_q[i] <= top_q);
    assign hit[i] = adv && live && (cnt_q == ocr_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)                          ocr_q[i] <= '0;
      else if (wr_en && wr_sel == MY_SEL)  ocr_q[i] <= wr_data;
    end

    a_r4_dead_channel: assert property (@(posedge clk) disable iff (!rst_n)
      (ocr_q[i] == '0 || ocr_q[i] > top_q) |=> !cmp_pulse[i]);
    a_r5_with_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ocr_q[i] == top_q && cnt_q == top_q) |=> (cmp_pulse[i] && ovf_pulse));
    a_r10_cmp_single: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pulse[i] |=> !cmp_pulse[i]);
  end

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q != '0) |-> (cnt_q <= top_q));
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q == top_q) |=> (ovf_pulse && cnt_q == '0));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_q));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q == '0) |=> (!ovf_pulse && cmp_pulse == '0));
  a_r10_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> flags[0]);
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam int CW = 16;
  typedef struct {
    logic [CW-1:0] cnt;
    logic          ovf;
    logic [2:0]    cmp;
    logic [3:0]    flg;
    string         tag;
  } item_t;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [2:0] wr_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count;
  logic ovf_pulse;
  logic [2:0] cmp_pulse;
  logic [3:0] flags;

  int total = 0, bad = 0;
  bit done = 0;
  item_t q[$];

  logic [CW-1:0] m_top = '0, m_cnt = '0;
  logic [CW-1:0] m_ocr [3] = '{default: '0};
  logic [3:0] m_flg = '0;

  always #10 clk = ~clk;

  cmp_timer #(.CW(CW), .NCMP(3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .count(count), .ovf_pulse(ovf_pulse),
    .cmp_pulse(cmp_pulse), .flags(flags));

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the expected result, push it
  task automatic cyc(bit t, bit w, logic [2:0] s, logic [CW-1:0] d, string tag);
    item_t it;
    bit acc;
    logic [2:0] h;
    logic [3:0] c;
    tick = t; wr_en = w; wr_sel = s; wr_data = d;
    acc = t && !w && m_top != 0;
    it.ovf = acc && m_cnt == m_top;
    for (int i = 0; i < 3; i++)
      h[i] = acc && m_ocr[i] != 0 && m_ocr[i] <= m_top && m_cnt == m_ocr[i];
    c = (w && s == 3'd5) ? d[3:0] : 4'b0;
    m_flg = {h, it.ovf} | (m_flg & ~c);
    if (w && s == 3'd0) begin m_top = d; m_cnt = '0; end
    else if (w && s == 3'd1) m_cnt = (d >= m_top) ? '0 : d;
    else if (w && s >= 3'd2 && s <= 3'd4) m_ocr[s-2] = d;
    else if (acc) m_cnt = it.ovf ? '0 : m_cnt + 1'b1;
    it.cnt = m_cnt; it.cmp = h; it.flg = m_flg; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      chk(count == e.cnt, {e.tag, " count R1"}, count, e.cnt);
      chk(ovf_pulse == e.ovf, {e.tag, " overflow R10"}, ovf_pulse, e.ovf);
      chk(cmp_pulse == e.cmp, {e.tag, " match R3"}, cmp_pulse, e.cmp);
      chk(flags == e.flg, {e.tag, " flags R8"}, flags, e.flg);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(count == 0 && ovf_pulse == 0 && cmp_pulse == 0 && flags == 0,
        "reset state R1", count, 0);
    rst_n = 1;
    // R9: TOP=0 idle under ticks
    repeat (4) cyc(1, 0, 0, 0, "R9 idle");
    // R6: set TOP=4, compare A=2, B=4 (R5), C=0 (R4)
    cyc(0, 1, 0, 4, "R6 top");
    cyc(0, 1, 2, 2, "R7 ocrA");
    cyc(0, 1, 3, 4, "R5 ocrB");
    cyc(0, 1, 4, 0, "R4 ocrC zero");
    // R2: sparse ticks, two full periods
    for (int k = 0; k < 20; k++) cyc(k % 2, 0, 0, 0, "R2 sparse");
    // R4: C above TOP stays silent
    cyc(0, 1, 4, 7, "R4 ocrC high");
    for (int k = 0; k < 10; k++) cyc(1, 0, 0, 0, "R4 run");
    // R8: clear A and overflow flags, then clear colliding with event
    cyc(0, 1, 5, 4'b0011, "R8 clear");
    cyc(0, 1, 1, 3, "R7 load 3");
    cyc(1, 0, 0, 0, "R5 wrap");
    cyc(0, 1, 5, 4'b1111, "R8 clear all");
    cyc(1, 0, 0, 0, "R8 tick");
    cyc(1, 1, 5, 4'b0001, "R7 tick during write");
    // R7: counter loads at and above TOP clear
    cyc(0, 1, 1, 4, "R7 load top");
    cyc(0, 1, 1, 9, "R7 load high");
    cyc(0, 1, 1, 2, "R7 load 2");
    cyc(1, 0, 0, 0, "R3 hit at load");
    // R6: rewriting TOP mid-count restarts with no overflow
    cyc(1, 0, 0, 0, "R6 pre");
    cyc(0, 1, 0, 1, "R6 top 1");
    cyc(0, 1, 2, 1, "R10 ocrA 1");
    for (int k = 0; k < 8; k++) cyc(1, 0, 0, 0, "R10 fast");
    cyc(0, 1, 0, 0, "R9 stop");
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, "R9 idle again");
    cyc(0, 0, 0, 0, "drain");
    @(negedge clk);
    finish_run();
  end
endmodule